// File: doc/BRIEF.md
# D-PHY Power-Up Reset Sequencer

This block brings a serial display PHY out of reset once its registers have been configured. On a start request it walks the three PHY control lines through a fixed, staggered release. The clock enable is raised first. The shutdown line is released about one microsecond later, and the reset line about one microsecond after that. The block then lets the PHY settle for about a millisecond and polls the PHY status vector once per microsecond. It stops polling when the PLL reports lock or the clock lane reports its stop state.

If neither indication arrives within a bounded number of samples, the block gives up and raises a timeout flag instead of the ready flag. A shutdown request returns the control word to all zero from any state and drops both flags. All delays are counted with one shared microsecond prescaler. The prescaler and the delays are sized from parameters in clock cycles per microsecond and in microseconds.

Top module: `phy_pwrup_seq`

## Requirements
- R1: After reset, `phyCtrl` is 3'b000 and `phyReady` and `phyTimeout` are both 0.
- R2: A start request accepted in the idle or finished state sets `phyCtrl` to 3'b100 (bit 2 = clock enable only). It holds that value for STEP_US*CYCLES_PER_US cycles, counted from the accepting clock edge.
- R3: The control word then becomes 3'b101 (bit 0 = shutdown released) for a further STEP_US*CYCLES_PER_US cycles.
- R4: The control word then becomes 3'b111 (bit 1 = reset released) and keeps that value until a shutdown. The first status sample is taken (SETTLE_US+1)*CYCLES_PER_US cycles after the word reaches 3'b111, and later samples follow every CYCLES_PER_US cycles.
- R5: Status passes through SYNC_STAGES flip-flops before it is sampled. A sample with bit 0 (PLL lock) or bit 2 (clock lane stopped) set ends polling and raises `phyReady`. Bit 1 alone has no effect.
- R6: If POLL_LIMIT samples pass without a hit, `phyTimeout` rises at the edge of the last sample. A hit on that last sample yields `phyReady` and no timeout.
- R7: `phyReady` and `phyTimeout` are never both 1. Each stays set until a shutdown or an accepted start, and `phyCtrl` stays 3'b111 while either is set.
- R8: A shutdown request in any state forces `phyCtrl` to 3'b000 and clears both flags at the next edge. Shutdown wins over a start request in the same cycle.
- R9: A start request during a running sequence is ignored and the timing of the sequence is unchanged. An accepted start clears both flags at its edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to run the power-up sequence |
| shutReq | input | 1 | Request to shut the PHY down |
| phyStatus | input | 3 | PHY status: bit 0 PLL lock, bit 2 clock lane stop state |
| phyCtrl | output | 3 | Control word: bit 2 clock enable, bit 1 reset released, bit 0 shutdown released |
| phyReady | output | 1 | Sticky: PHY reported readiness |
| phyTimeout | output | 1 | Sticky: polling gave up without readiness |

## Verification
Three collisions are tested. The first is a status hit that lands on the final poll sample. The bench drives the status so that it becomes visible exactly at that sample, and it expects ready and not timeout. The second is a shutdown and a start request asserted in the same cycle, both from idle and from the finished state. The bench expects the control word to stay zero and the flags to be cleared. The third is a start request injected into a running sequence, which is judged by checking every cycle of the control-word schedule against the undisturbed timing.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

  localparam int STATUS_W = 3;
  // status bits that signal readiness: PLL lock (bit 0) and clock-lane stop (bit 2)
  localparam logic [STATUS_W-1:0] HIT_MASK = 3'b101;

  localparam logic [2:0] CTRL_OFF      = 3'b000;
  localparam logic [2:0] CTRL_CLK      = 3'b100;
  localparam logic [2:0] CTRL_CLK_SHUT = 3'b101;
  localparam logic [2:0] CTRL_ALL      = 3'b111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLK_ON,
    ST_SHUT_OFF,
    ST_SETTLE,
    ST_POLL,
    ST_DONE
  } seqStateT;

  typedef struct packed {
    logic timerClr;
    logic timerRun;
  } seqStrobeT;

  function automatic int maxOf3(int a, int b, int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/pwrup_seq_timer.sv
module pwrup_seq_timer
  import pwrup_seq_pkg::*;
#(
  parameter int CYCLES_PER_US = 250,
  parameter int SYNC_STAGES   = 2,
  parameter int CNT_W         = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobeT           strobe,
  input  logic [STATUS_W-1:0] phyStatus,
  output logic                usTick,
  output logic [CNT_W-1:0]    usCount,
  output logic                statusHit
);

  localparam int PRE_W = (CYCLES_PER_US > 1) ? $clog2(CYCLES_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYCLES_PER_US - 1);

  logic [PRE_W-1:0]    preCnt;
  logic [STATUS_W-1:0] statusSync;

  assign usTick = strobe.timerRun && (preCnt == PRE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      usCount <= '0;
    end else if (strobe.timerClr) begin
      preCnt  <= '0;
      usCount <= '0;
    end else if (strobe.timerRun) begin
      if (preCnt == PRE_LAST) begin
        preCnt  <= '0;
        usCount <= usCount + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  generate
    if (SYNC_STAGES == 0) begin : g_noSync
      assign statusSync = phyStatus;
    end else begin : g_sync
      logic [STATUS_W-1:0] syncQ [SYNC_STAGES];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '0;
        end else begin
          syncQ[0] <= phyStatus;
          for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
        end
      end
      assign statusSync = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  assign statusHit = |(statusSync & HIT_MASK);

  // microsecond ticks are at least two cycles apart (timing base of R4)
  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rstN)
    (usTick && !strobe.timerClr) |=> !usTick);

endmodule

// File: rtl/pwrup_seq_ctrl.sv
module pwrup_seq_ctrl
  import pwrup_seq_pkg::*;
#(
  parameter int STEP_US    = 1,
  parameter int SETTLE_US  = 1000,
  parameter int POLL_LIMIT = 100,
  parameter int CNT_W      = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             shutReq,
  input  logic             usTick,
  input  logic [CNT_W-1:0] usCount,
  input  logic             statusHit,
  output seqStrobeT        strobe,
  output logic [2:0]       phyCtrl,
  output logic             phyReady,
  output logic             phyTimeout
);

  localparam logic [CNT_W-1:0] STEP_LAST   = CNT_W'(STEP_US - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_US - 1);
  localparam logic [CNT_W-1:0] POLL_LAST   = CNT_W'(POLL_LIMIT - 1);

  seqStateT state, stateNext;
  logic     startOk, setReady, setTimeout;

  assign startOk = startReq && !shutReq && (state == ST_IDLE || state == ST_DONE);

  always_comb begin
    stateNext       = state;
    strobe.timerClr = 1'b0;
    strobe.timerRun = (state == ST_CLK_ON) || (state == ST_SHUT_OFF) ||
                      (state == ST_SETTLE) || (state == ST_POLL);
    setReady        = 1'b0;
    setTimeout      = 1'b0;
    if (shutReq) begin
      stateNext       = ST_IDLE;
      strobe.timerClr = 1'b1;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (startReq) begin
            stateNext       = ST_CLK_ON;
            strobe.timerClr = 1'b1;
          end
        end
        ST_CLK_ON: begin
          if (usTick && usCount == STEP_LAST) begin
            stateNext       = ST_SHUT_OFF;
            strobe.timerClr = 1'b1;
          end
        end
        ST_SHUT_OFF: begin
          if (usTick && usCount == STEP_LAST) begin
            stateNext       = ST_SETTLE;
            strobe.timerClr = 1'b1;
          end
        end
        ST_SETTLE: begin
          if (usTick && usCount == SETTLE_LAST) begin
            stateNext       = ST_POLL;
            strobe.timerClr = 1'b1;
          end
        end
        ST_POLL: begin
          if (usTick) begin
            if (statusHit) begin
              stateNext = ST_DONE;
              setReady  = 1'b1;
            end else if (usCount == POLL_LAST) begin
              stateNext  = ST_DONE;
              setTimeout = 1'b1;
            end
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phyReady   <= 1'b0;
      phyTimeout <= 1'b0;
    end else begin
      state <= stateNext;
      if (shutReq || startOk) begin
        phyReady   <= 1'b0;
        phyTimeout <= 1'b0;
      end else begin
        if (setReady)   phyReady   <= 1'b1;
        if (setTimeout) phyTimeout <= 1'b1;
      end
    end
  end

  always_comb begin
    case (state)
      ST_IDLE:     phyCtrl = CTRL_OFF;
      ST_CLK_ON:   phyCtrl = CTRL_CLK;
      ST_SHUT_OFF: phyCtrl = CTRL_CLK_SHUT;
      default:     phyCtrl = CTRL_ALL;
    endcase
  end

  assert_shut_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    shutReq |=> (phyCtrl == CTRL_OFF && !phyReady && !phyTimeout));

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(phyReady && phyTimeout));

  assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (phyReady && !startReq && !shutReq) |=> phyReady);

  assert_first_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phyCtrl == CTRL_OFF) |=> (phyCtrl == CTRL_OFF || phyCtrl == CTRL_CLK));

  assert_second_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phyCtrl == CTRL_CLK) |=> (phyCtrl != CTRL_ALL));

  assert_full_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    (phyCtrl == CTRL_ALL && !shutReq && !startReq) |=> (phyCtrl == CTRL_ALL));

  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    startOk |=> (phyCtrl == CTRL_CLK && !phyReady && !phyTimeout));

endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
  import pwrup_seq_pkg::*;
#(
  parameter int CYCLES_PER_US = 250,
  parameter int STEP_US       = 1,
  parameter int SETTLE_US     = 1000,
  parameter int POLL_LIMIT    = 100,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       shutReq,
  input  logic [2:0] phyStatus,
  output logic [2:0] phyCtrl,
  output logic       phyReady,
  output logic       phyTimeout
);

  localparam int MAX_US = maxOf3(STEP_US, SETTLE_US, POLL_LIMIT);
  localparam int CNT_W  = $clog2(MAX_US + 1);

  seqStrobeT        strobe;
  logic             usTick;
  logic [CNT_W-1:0] usCount;
  logic             statusHit;

  pwrup_seq_ctrl #(
    .STEP_US(STEP_US), .SETTLE_US(SETTLE_US),
    .POLL_LIMIT(POLL_LIMIT), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .shutReq(shutReq),
    .usTick(usTick), .usCount(usCount), .statusHit(statusHit),
    .strobe(strobe), .phyCtrl(phyCtrl), .phyReady(phyReady),
    .phyTimeout(phyTimeout)
  );

  pwrup_seq_timer #(
    .CYCLES_PER_US(CYCLES_PER_US), .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rstN(rstN), .strobe(strobe), .phyStatus(phyStatus),
    .usTick(usTick), .usCount(usCount), .statusHit(statusHit)
  );

endmodule

// File: tb/phy_pwrup_seq_test.sv
`timescale 1ns/1ps
module phy_pwrup_seq_test;

  localparam int CPU    = 4;
  localparam int STEP   = 1;
  localparam int SETTLE = 5;
  localparam int NPOLL  = 6;
  localparam int SYNC   = 2;
  localparam int PH1    = STEP * CPU;
  localparam int PH2    = 2 * STEP * CPU;
  localparam int POLL0  = (2 * STEP + SETTLE) * CPU;
  localparam int TEND   = POLL0 + NPOLL * CPU;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic shutReq = 1'b0;
  logic [2:0] phyStatus = 3'b000;
  logic [2:0] phyCtrl;
  logic phyReady, phyTimeout;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  phy_pwrup_seq #(
    .CYCLES_PER_US(CPU), .STEP_US(STEP), .SETTLE_US(SETTLE),
    .POLL_LIMIT(NPOLL), .SYNC_STAGES(SYNC)
  ) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .shutReq(shutReq),
    .phyStatus(phyStatus), .phyCtrl(phyCtrl), .phyReady(phyReady),
    .phyTimeout(phyTimeout)
  );

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // control word expected k edges after the accepting start edge (R2, R3, R4)
  function automatic int expCtrl(int k);
    if (k < PH1) return 4;
    if (k < PH2) return 5;
    return 7;
  endfunction

  // edge index of the sample that finds readiness; -1 if none (R5, R6)
  function automatic int expHitEdge(int d, logic [2:0] bits);
    if ((bits & 3'b101) == 3'b000) return -1;
    for (int j = 1; j <= NPOLL; j++) begin
      if (POLL0 + j * CPU > d + SYNC) return POLL0 + j * CPU;
    end
    return -1;
  endfunction

  // full run: status 'bits' appears right after edge d; optional stray start at busyAt
  task automatic runSeq(int d, logic [2:0] bits, int busyAt);
    int hitE;
    hitE = expHitEdge(d, bits);
    phyStatus = 3'b000;
    @(negedge clk) startReq = 1'b1;
    @(posedge clk) #1 startReq = 1'b0;
    chk("R2 ctrl at start", phyCtrl, 4);
    chk("R9 ready cleared by start", phyReady, 0);
    chk("R9 timeout cleared by start", phyTimeout, 0);
    for (int k = 1; k <= TEND + 3; k++) begin
      @(posedge clk) #1;
      startReq = (k == busyAt);
      if (k == d) phyStatus = bits;
      chk("R2/R3/R4/R9 ctrl schedule", phyCtrl, expCtrl(k));
      chk("R5/R6 ready", phyReady, (hitE >= 0 && k >= hitE) ? 1 : 0);
      chk("R6 timeout", phyTimeout, (hitE < 0 && k >= TEND) ? 1 : 0);
      if (phyReady && phyTimeout) chk("R7 exclusive flags", 1, 0);
    end
    startReq = 1'b0;
  endtask

  task automatic shutPulse(logic withStart);
    @(negedge clk) begin shutReq = 1'b1; startReq = withStart; end
    @(posedge clk) #1 begin shutReq = 1'b0; startReq = 1'b0; end
    chk("R8 ctrl off after shutdown", phyCtrl, 0);
    chk("R8 ready dropped", phyReady, 0);
    chk("R8 timeout dropped", phyTimeout, 0);
  endtask

  initial begin
    #400000;
    nFails++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [2:0] bits;
    int d, busyAt;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset ctrl", phyCtrl, 0);
    chk("R1 reset ready", phyReady, 0);
    chk("R1 reset timeout", phyTimeout, 0);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1 chk("R1 idle ctrl", phyCtrl, 0);

    // directed corner cases
    runSeq(1, 3'b001, -1);                        // R5 lock early
    runSeq(3, 3'b100, -1);                        // R5 stop state
    runSeq(5, 3'b010, -1);                        // R5 bit 1 ignored -> timeout
    runSeq(TEND - SYNC - 1, 3'b001, -1);          // R6 hit on last sample
    runSeq(TEND - SYNC, 3'b100, -1);              // R6 one cycle too late
    runSeq(40, 3'b101, 6);                        // R9 start during run ignored
    shutPulse(1'b0);                              // R8 clears ready

    runSeq(60, 3'b000, -1);                       // timeout
    shutPulse(1'b1);                              // R8 shut beats start from done
    repeat (5) @(posedge clk);
    #1 chk("R8 stays idle", phyCtrl, 0);
    shutPulse(1'b1);                              // R8 shut beats start from idle

    // shutdown mid-sequence
    @(negedge clk) startReq = 1'b1;
    @(posedge clk) #1 startReq = 1'b0;
    repeat (12) @(posedge clk);
    #1 chk("R4 ctrl before shutdown", phyCtrl, 7);
    shutPulse(1'b0);
    repeat (8) @(posedge clk);
    #1 chk("R8 idle after shutdown", phyCtrl, 0);

    // random runs
    for (int r = 0; r < 24; r++) begin
      d = $urandom_range(1, 60);
      bits = 3'($urandom_range(0, 7));
      busyAt = ($urandom_range(0, 1) == 1) ? $urandom_range(2, 20) : -1;
      runSeq(d, bits, busyAt);
      if ($urandom_range(0, 3) == 0) shutPulse(1'b0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule